// File: doc/BRIEF.md
# Integer-N Frequency Synthesizer Digital Core

This block is the digital heart of an integer-N frequency synthesizer. A fast core clock oversamples two incoming square waves: a crystal clock and the output of an external oscillator. A reference counter divides the crystal edges by a fixed ratio to make the comparison rate. A feedback counter divides the oscillator edges by a programmable ratio N. Each counter ends its cycle with a terminal event, which marks the falling edge of its divided signal. A tri-state phase/frequency detector compares the two events. It asks the charge pump to source current when the divided oscillator is early and to sink current when it is late. When the two events coincide it leaves the pump output floating.

Software writes the ratio N and a boost bit. The boost bit picks a pump magnitude of 1x or 5x, so the loop can acquire fast and then settle gently. A lock flag reports that the phase error has stayed small for several comparison periods in a row. The charge pump, loop filter and oscillator are analog and lie outside this block.

Top module: `isyn_core`

## Requirements
- R1: After reset, pump_up=0, pump_dn=0, pump_hiz=1, pump_x5=0 and locked=0.
- R2: A reference event occurs on the first crystal rising edge after reset and then on every REF_DIV-th crystal rising edge.
- R3: A feedback event occurs on the first oscillator rising edge after reset and then after every N oscillator rising edges. N is n_ratio with its most significant bit forced to 1, so with DIV_W=4 a written value of 2 acts as 10.
- R4: A new n_ratio takes effect only when the feedback counter reloads at its terminal event. The period already in progress completes with the old ratio.
- R5: A feedback event that comes d core cycles before the matching reference event drives pump_up high for exactly d consecutive cycles.
- R6: A reference event that comes d core cycles before the matching feedback event drives pump_dn high for exactly d consecutive cycles.
- R7: When the two events fall in the same core cycle, neither pump output goes high. pump_hiz is 1 exactly when neither pump_up nor pump_dn is high.
- R8: pump_x5 takes the value of boost only while the pump is idle. During a pump pulse it keeps its value and updates once the pulse has ended.
- R9: locked rises after LOCK_RUN consecutive reference periods in which each pulse width is at most LOCK_TOL cycles. It falls at the end of the first reference period whose pulse is wider than that.
- R10: pump_up and pump_dn are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| xtal_in | input | 1 | Crystal clock, sampled by clk |
| osc_in | input | 1 | Oscillator signal, sampled by clk |
| n_ratio | input | DIV_W | Feedback divide ratio (MSB forced to 1) |
| boost | input | 1 | Pump magnitude select: 1 = 5x, 0 = 1x |
| pump_up | output | 1 | Charge-pump source request |
| pump_dn | output | 1 | Charge-pump sink request |
| pump_hiz | output | 1 | Pump output floating |
| pump_x5 | output | 1 | Applied pump magnitude (1 = 5x) |
| locked | output | 1 | Phase lock indication |

## Verification
The bench builds the core with REF_DIV=20, DIV_W=4, LOCK_TOL=1 and LOCK_RUN=4. With a two-cycle crystal and a four-cycle oscillator, a ratio of 10 gives matched 40-cycle periods, so a run of four comparisons fits in about 160 cycles. The small ratio field makes the forced MSB visible with a written value of 2, and a mid-period change from 10 to 11 shows where the ratio is taken up. The tolerance of one cycle places the lock boundary between a one-cycle lead and a two-cycle lead.

// File: rtl/isyn_pkg.sv
package isyn_pkg;
    // Pump request pair held by the detector flops
    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;
endpackage

// File: rtl/isyn_edge_sync.sv
module isyn_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.s1 = sig_in;
        smp_d.s2 = smp_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= smp_d;
    end

    assign rise_o = smp_q.s1 & ~smp_q.s2;
endmodule

// File: rtl/isyn_count_div.sv
module isyn_count_div #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         term_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic at_end;

    assign at_end = (div_q.cnt <= W'(1));

    always_comb begin
        div_d = div_q;
        if (tick) begin
            if (at_end) div_d.cnt = reload;
            else        div_d.cnt = div_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_q.cnt <= W'(1);
        else     div_q     <= div_d;
    end

    assign term_o = tick & at_end;
endmodule

// File: rtl/isyn_pfd.sv
module isyn_pfd
    import isyn_pkg::*;
#(
    parameter int LOCK_TOL = 2,
    parameter int LOCK_RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_ev,
    input  logic ref_ev,
    input  logic boost,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic pump_x5,
    output logic locked
);
    localparam int ACC_W = $clog2(LOCK_TOL + 2);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);
    localparam logic [ACC_W:0]   TOL_V   = (ACC_W+1)'(LOCK_TOL);

    typedef struct packed {
        pump_req_t         req;
        logic              x5;
        logic              lck;
        logic [ACC_W-1:0]  acc;
        logic [RUN_W-1:0]  good;
    } pfd_t;

    pfd_t pfd_d, pfd_q;
    logic active;
    logic [ACC_W:0] width;

    assign active = pfd_q.req.up ^ pfd_q.req.dn;
    assign width  = {1'b0, pfd_q.acc} + (ACC_W+1)'(active);

    always_comb begin
        pfd_d = pfd_q;
        // Tri-state flops: once both are set they clear together
        if (pfd_q.req.up & pfd_q.req.dn) begin
            pfd_d.req.up = fb_ev;
            pfd_d.req.dn = ref_ev;
        end else begin
            pfd_d.req.up = pfd_q.req.up | fb_ev;
            pfd_d.req.dn = pfd_q.req.dn | ref_ev;
        end
        // Magnitude may only move while no current flows
        if (!active) pfd_d.x5 = boost;
        // Error width per reference window and lock run length
        if (ref_ev) begin
            pfd_d.acc = '0;
            if (width <= TOL_V) begin
                if (pfd_q.good != RUN_TOP) pfd_d.good = pfd_q.good + RUN_W'(1);
            end else begin
                pfd_d.good = '0;
            end
            pfd_d.lck = (pfd_d.good == RUN_TOP);
        end else if (active && (pfd_q.acc != ACC_MAX)) begin
            pfd_d.acc = pfd_q.acc + ACC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pfd_q <= '0;
        else     pfd_q <= pfd_d;
    end

    assign pump_up  = pfd_q.req.up & ~pfd_q.req.dn;
    assign pump_dn  = pfd_q.req.dn & ~pfd_q.req.up;
    assign pump_hiz = ~active;
    assign pump_x5  = pfd_q.x5;
    assign locked   = pfd_q.lck;
endmodule

// File: rtl/isyn_core.sv
module isyn_core #(
    parameter int REF_DIV  = 400,
    parameter int DIV_W    = 11,
    parameter int LOCK_TOL = 2,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_in,
    input  logic             osc_in,
    input  logic [DIV_W-1:0] n_ratio,
    input  logic             boost,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_hiz,
    output logic             pump_x5,
    output logic             locked
);
    localparam int REF_W = $clog2(REF_DIV + 1);
    localparam logic [REF_W-1:0] REF_LOAD = REF_W'(REF_DIV);
    localparam logic [DIV_W-1:0] N_MSB    = {1'b1, {(DIV_W-1){1'b0}}};

    logic xtal_rise, osc_rise;
    logic ref_ev, fb_ev;
    logic [DIV_W-1:0] fb_load;

    assign fb_load = n_ratio | N_MSB;

    isyn_edge_sync u_xsync (
        .clk(clk), .rst(rst), .sig_in(xtal_in), .rise_o(xtal_rise)
    );

    isyn_edge_sync u_osync (
        .clk(clk), .rst(rst), .sig_in(osc_in), .rise_o(osc_rise)
    );

    isyn_count_div #(.W(REF_W)) u_refdiv (
        .clk(clk), .rst(rst), .tick(xtal_rise), .reload(REF_LOAD), .term_o(ref_ev)
    );

    isyn_count_div #(.W(DIV_W)) u_fbdiv (
        .clk(clk), .rst(rst), .tick(osc_rise), .reload(fb_load), .term_o(fb_ev)
    );

    isyn_pfd #(.LOCK_TOL(LOCK_TOL), .LOCK_RUN(LOCK_RUN)) u_pfd (
        .clk(clk), .rst(rst), .fb_ev(fb_ev), .ref_ev(ref_ev), .boost(boost),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .pump_x5(pump_x5), .locked(locked)
    );
endmodule

// File: rtl/isyn_core_chk.sv
module isyn_core_chk (
    input logic clk,
    input logic rst,
    input logic ref_ev,
    input logic fb_ev,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_hiz,
    input logic pump_x5,
    input logic locked
);
    // R8
    x5_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pump_x5) |-> $past(pump_hiz));

    // R5
    up_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pump_up) |-> $past(fb_ev));

    // R6
    dn_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pump_dn) |-> $past(ref_ev));

    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_ev));

    // R9
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(ref_ev));
endmodule

bind isyn_core isyn_core_chk u_chk (
    .clk(clk), .rst(rst), .ref_ev(ref_ev), .fb_ev(fb_ev),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .pump_x5(pump_x5), .locked(locked)
);

// File: tb/sim_isyn_core.sv
module sim_isyn_core;
    localparam int REF_DIV = 20;
    localparam int DIV_W   = 4;
    localparam int TOL     = 1;
    localparam int RUNS    = 4;
    localparam int XP      = 2;            // crystal period in core cycles
    localparam int PO      = 4;            // oscillator period in core cycles
    localparam int RP      = REF_DIV * XP; // reference period: 40 cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xtal_in = 1'b0;
    logic osc_in = 1'b0;
    logic boost = 1'b0;
    logic [DIV_W-1:0] n_ratio = 4'd10;
    logic pump_up, pump_dn, pump_hiz, pump_x5, locked;

    always #2 clk = ~clk;

    isyn_core #(.REF_DIV(REF_DIV), .DIV_W(DIV_W), .LOCK_TOL(TOL), .LOCK_RUN(RUNS)) u0 (
        .clk(clk), .rst(rst), .xtal_in(xtal_in), .osc_in(osc_in),
        .n_ratio(n_ratio), .boost(boost),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .pump_x5(pump_x5), .locked(locked)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run = 1'b0;
    int x0 = 0;
    int o0 = 0;
    bit done = 1'b0;

    typedef struct { bit up; int w; } exp_t;
    exp_t expq[$];

    // Stimulus generator: square waves started at x0 / o0
    always @(negedge clk) begin
        cyc = cyc + 1;
        xtal_in = run && (cyc >= x0) && (((cyc - x0) % XP) == 0);
        osc_in  = run && (cyc >= o0) && (((cyc - o0) % PO) < (PO / 2));
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: measures every pump pulse and compares with the scoreboard
    int run_len = 0;
    bit run_up = 1'b0;
    int overlap = 0;
    int hizbad = 0;
    always @(negedge clk) begin
        if (rst) begin
            run_len = 0;
        end else begin
            if (pump_up && pump_dn) overlap++;                 // R10
            if (pump_hiz != !(pump_up || pump_dn)) hizbad++;   // R7
            if (pump_up || pump_dn) begin
                if (run_len == 0) run_up = pump_up;
                run_len++;
            end else if (run_len > 0) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R5/R6 unexpected pulse: actual up=%0d width=%0d expected none",
                             run_up, run_len);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.up != run_up || e.w != run_len) begin
                        errors++;
                        $display("FAIL %s pulse: actual up=%0d width=%0d expected up=%0d width=%0d",
                                 e.up ? "R5" : "R6", run_up, run_len, e.up, e.w);
                    end
                end
                run_len = 0;
            end
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Driver: lead > 0 means the oscillator starts first
    task automatic start_run(int lead, int npush);
        int base;
        exp_t e;
        base = cyc + 10;
        o0 = base + ((lead > 0) ? 0 : -lead);
        x0 = base + ((lead > 0) ? lead : 0);
        e.up = (lead > 0);
        e.w  = (lead > 0) ? lead : -lead;
        for (int k = 0; k < npush; k++) expq.push_back(e);
        run = 1'b1;
    endtask

    task automatic end_run();
        run = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        chk("R5/R6", "missing pulses", expq.size(), 0);
        expq.delete();
    endtask

    function automatic int stop_at(int periods);
        return ((x0 > o0) ? x0 : o0) + RP * (periods - 1) + 6;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "pump_up", pump_up, 0);
        chk("R1", "pump_dn", pump_dn, 0);
        chk("R1", "pump_hiz", pump_hiz, 1);
        chk("R1", "pump_x5", pump_x5, 0);
        chk("R1", "locked", locked, 0);

        // R7/R9: matched ratio, coincident events, no pulses, lock after four periods
        n_ratio = 4'd10;
        start_run(0, 0);
        wait_until(x0 + RP * 2 + 5);
        chk("R9", "locked after three periods", locked, 0);
        chk("R7", "pump_hiz while coincident", pump_hiz, 1);
        wait_until(x0 + RP * 3 + 5);
        chk("R2/R9", "locked after four periods", locked, 1);
        wait_until(stop_at(6));
        end_run();

        // R5: oscillator leads by 3 cycles, lock never reached
        start_run(3, 5);
        wait_until(stop_at(5));
        chk("R9", "locked with 3-cycle error", locked, 0);
        end_run();

        // R6 and R8: oscillator lags by 5, boost toggled inside a pulse
        start_run(-5, 5);
        while (!pump_dn) begin
            @(negedge clk);
            #1;
        end
        boost = 1'b1;
        @(negedge clk);
        #1;
        chk("R8", "pump_x5 held during pulse", pump_x5, 0);
        while (pump_dn) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        #1;
        chk("R8", "pump_x5 after pulse", pump_x5, 1);
        boost = 1'b0;
        wait_until(stop_at(5));
        end_run();

        // R9 boundary: lead of one cycle is within tolerance
        start_run(1, 6);
        wait_until(x0 + RP * 3 + 5);
        chk("R9", "locked with 1-cycle error", locked, 1);
        wait_until(stop_at(6));
        end_run();

        // R9 boundary: lead of two cycles exceeds tolerance
        start_run(2, 6);
        wait_until(stop_at(6));
        chk("R9", "locked with 2-cycle error", locked, 0);
        end_run();

        // R3: written ratio 2 behaves as 10 (MSB forced)
        n_ratio = 4'd2;
        start_run(0, 0);
        wait_until(x0 + RP * 3 + 5);
        chk("R2/R3", "locked with forced MSB", locked, 1);
        wait_until(stop_at(5));
        end_run();

        // R4: ratio 11 for one period, taken at the terminal event only
        n_ratio = 4'd10;
        start_run(0, 0);
        wait_until(x0 + RP * 4 + 20);
        chk("R9", "locked before ratio change", locked, 1);
        n_ratio = 4'd11;
        wait_until(x0 + RP * 4 + 60);
        n_ratio = 4'd10;
        for (int k = 0; k < 3; k++) begin
            exp_t e;
            e.up = 1'b0;
            e.w  = 4;
            expq.push_back(e);
        end
        wait_until(x0 + RP * 6 + 5);
        chk("R4", "still locked one period after reload", locked, 1);
        wait_until(x0 + RP * 7 + 6);
        chk("R9", "lock lost after wide pulse", locked, 0);
        wait_until(x0 + RP * 8 + 10);
        end_run();

        chk("R10", "cycles with both pump outputs high", overlap, 0);
        chk("R7", "cycles with wrong pump_hiz", hizbad, 0);

        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule